// File: doc/BRIEF.md
# Serial Interrupt Host Controller

This block is the host end of a shared, open-drain serialized interrupt line clocked by the PCI clock. It frames each polling cycle. A cycle opens with a start pulse driven low, followed by one clock driven high. Then come sixteen three-clock interrupt/data slots, during which peripherals pull the line low to signal their request. A short stop pulse closes the cycle and tells the peripherals which mode the next cycle uses. After every stop frame the block publishes the rebuilt request vector as one word.

There are two modes. In continuous mode the host opens every cycle itself, after a fixed idle gap. In quiet mode the host stays silent until a peripheral pulls the line low for one clock. The host then continues that low pulse so that the total start width matches the programmed setting. The line itself is modelled as a pad enable and a pad value, with the pulled-up pad level fed back on a separate input.

Top module: `sirq_host`

## Requirements
- R1: While reset is asserted, the pad enable is 0 and the request vector is all zeros, and the controller is in continuous mode. The first start frame is driven from the first clock edge after reset is released.
- R2: In continuous mode the start pulse is driven low for 4 + W clocks, where W is the start width code. Codes 5, 6 and 7 give 8 clocks.
- R3: In quiet mode the host never opens a cycle by itself. When it samples the line low during idle, it drives the line low from the next clock for 3 + W further clocks. Codes 5 to 7 give 7 clocks.
- R4: After the start low pulse the host drives the line high for exactly one clock. It then releases the line for all 48 clocks of the sixteen data frames.
- R5: Data frame k (k = 0 to 15) is three clocks long and is sampled in its first clock. A low level there sets vector bit k to 1, and a high level sets it to 0.
- R6: The stop frame drives the line low for 2 clocks when the mode select is 1 at the end of the last data frame. It drives the line low for 3 clocks when the mode select is 0. Either way it then drives high for one clock and releases the line.
- R7: The request vector changes only in the clock after the stop frame's high clock. It holds the previous cycle's value throughout the current cycle.
- R8: In continuous mode the next start pulse begins exactly IDLE_GAP (default 4) released clocks after the stop frame. A low level on the line during that gap has no effect.
- R9: A 2-clock stop frame puts the next cycle in quiet mode, and a 3-clock stop frame puts it in continuous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quiet_mode_i | input | 1 | Mode for the next cycle: 1 quiet, 0 continuous |
| start_width_i | input | 3 | Start width code W |
| line_i | input | 1 | Pad level of the shared line |
| line_oe_o | output | 1 | Pad drive enable |
| line_out_o | output | 1 | Pad drive value when enabled |
| irq_vec_o | output | 16 | Request vector, bit k = frame k asserted |

## Verification
Most state faults show at the pad within one cycle of the fault. A wrong counter preset shows up as a start or stop pulse of the wrong length. A wrong phase count moves the high clock or shifts a sampled bit into a neighbouring position. Both are visible at the latest when the vector is published after the stop frame. A wrong mode register shows up one cycle later. The host then opens a cycle without a peripheral request, or sits idle when it should start after the fixed gap.

// File: rtl/sirq_host_pkg.sv
package sirq_host_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_START_HI,
    ST_FRAME,
    ST_STOP,
    ST_STOP_HI
  } sirq_state_e;
endpackage

// File: rtl/sirq_host_seq.sv
module sirq_host_seq
  import sirq_host_pkg::*;
#(
  parameter int NUM_FRAMES = 16,
  parameter int IDLE_GAP   = 4,
  localparam int FIDX_W    = $clog2(NUM_FRAMES),
  localparam int CNT_MAX   = (IDLE_GAP > 8) ? IDLE_GAP : 8,
  localparam int CNT_W     = $clog2(CNT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              quiet_mode_i,
  input  logic [2:0]        start_width_i,
  input  logic              line_i,
  output logic              line_oe_o,
  output logic              line_out_o,
  output logic              sample_en_o,
  output logic [FIDX_W-1:0] frame_o,
  output logic              commit_o
);

  sirq_state_e       st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [1:0]        phase_q, phase_d;
  logic [FIDX_W-1:0] frame_q, frame_d;
  logic              mode_q, mode_d;   // 1 = quiet
  logic [3:0]        low_len;

  // total start low clocks: 4 + W, clamped to 8
  always_comb begin
    if (start_width_i > 3'd4) low_len = 4'd8;
    else                      low_len = 4'd4 + {1'b0, start_width_i};
  end

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    phase_d = phase_q;
    frame_d = frame_q;
    mode_d  = mode_q;
    case (st_q)
      ST_IDLE: begin
        if (mode_q) begin
          if (!line_i) begin
            st_d  = ST_START;
            cnt_d = CNT_W'(low_len - 4'd2);
          end
        end else if (cnt_q == '0) begin
          st_d  = ST_START;
          cnt_d = CNT_W'(low_len - 4'd1);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_START: begin
        if (cnt_q == '0) st_d = ST_START_HI;
        else             cnt_d = cnt_q - CNT_W'(1);
      end
      ST_START_HI: begin
        st_d    = ST_FRAME;
        phase_d = 2'd0;
        frame_d = '0;
      end
      ST_FRAME: begin
        if (phase_q == 2'd2) begin
          phase_d = 2'd0;
          if (frame_q == FIDX_W'(NUM_FRAMES - 1)) begin
            st_d   = ST_STOP;
            mode_d = quiet_mode_i;
            cnt_d  = quiet_mode_i ? CNT_W'(1) : CNT_W'(2);
          end else begin
            frame_d = frame_q + FIDX_W'(1);
          end
        end else begin
          phase_d = phase_q + 2'd1;
        end
      end
      ST_STOP: begin
        if (cnt_q == '0) st_d = ST_STOP_HI;
        else             cnt_d = cnt_q - CNT_W'(1);
      end
      ST_STOP_HI: begin
        st_d  = ST_IDLE;
        cnt_d = CNT_W'(IDLE_GAP - 1);
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      phase_q <= 2'd0;
      frame_q <= '0;
      mode_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
      frame_q <= frame_d;
      mode_q  <= mode_d;
    end
  end

  assign line_oe_o   = (st_q == ST_START) || (st_q == ST_START_HI) ||
                       (st_q == ST_STOP)  || (st_q == ST_STOP_HI);
  assign line_out_o  = (st_q == ST_START_HI) || (st_q == ST_STOP_HI);
  assign sample_en_o = (st_q == ST_FRAME) && (phase_q == 2'd0);
  assign frame_o     = frame_q;
  assign commit_o    = (st_q == ST_STOP_HI);

  // R4: one high clock follows the last start low clock
  a_r4_high_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_START && cnt_q == '0) |=> (line_oe_o && line_out_o));

  // R6: every driven-high clock is followed by release
  a_r6_release_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    (line_oe_o && line_out_o) |=> !line_oe_o);

  // R3: quiet idle with a high line never starts a cycle
  a_r3_quiet_no_self_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && mode_q && line_i) |=> !line_oe_o);

  // R8: continuous idle gap not yet elapsed keeps the line released
  a_r8_gap_respected: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !mode_q && cnt_q != '0) |=> !line_oe_o);

endmodule

// File: rtl/sirq_host_capture.sv
module sirq_host_capture #(
  parameter int NUM_FRAMES = 16,
  localparam int FIDX_W    = $clog2(NUM_FRAMES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sample_en_i,
  input  logic [FIDX_W-1:0]     frame_i,
  input  logic                  line_i,
  input  logic                  commit_i,
  output logic [NUM_FRAMES-1:0] vec_o
);

  logic [NUM_FRAMES-1:0] samp_q;
  logic [NUM_FRAMES-1:0] vec_q;

  for (genvar k = 0; k < NUM_FRAMES; k++) begin : g_slot
    logic hit;
    assign hit = sample_en_i && (frame_i == FIDX_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   samp_q[k] <= 1'b0;
      else if (hit) samp_q[k] <= ~line_i;   // low level = request
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        vec_q <= '0;
    else if (commit_i) vec_q <= samp_q;
  end

  assign vec_o = vec_q;

  // R7: published vector moves only on the commit clock
  a_r7_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(vec_o));

endmodule

// File: rtl/sirq_host.sv
module sirq_host #(
  parameter int NUM_FRAMES = 16,
  parameter int IDLE_GAP   = 4,
  localparam int FIDX_W    = $clog2(NUM_FRAMES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  quiet_mode_i,
  input  logic [2:0]            start_width_i,
  input  logic                  line_i,
  output logic                  line_oe_o,
  output logic                  line_out_o,
  output logic [NUM_FRAMES-1:0] irq_vec_o
);

  logic              sample_en;
  logic [FIDX_W-1:0] frame_idx;
  logic              commit;

  sirq_host_seq #(
    .NUM_FRAMES (NUM_FRAMES),
    .IDLE_GAP   (IDLE_GAP)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .quiet_mode_i  (quiet_mode_i),
    .start_width_i (start_width_i),
    .line_i        (line_i),
    .line_oe_o     (line_oe_o),
    .line_out_o    (line_out_o),
    .sample_en_o   (sample_en),
    .frame_o       (frame_idx),
    .commit_o      (commit)
  );

  sirq_host_capture #(
    .NUM_FRAMES (NUM_FRAMES)
  ) u_capture (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_en_i (sample_en),
    .frame_i     (frame_idx),
    .line_i      (line_i),
    .commit_i    (commit),
    .vec_o       (irq_vec_o)
  );

endmodule

// File: tb/test_sirq_host.sv
`timescale 1ns/1ps
module test_sirq_host;

  localparam int GAP = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        quiet_sel;
  logic [2:0]  start_width;
  logic        line_in;
  logic        line_oe;
  logic        line_out;
  logic [15:0] irq_vec;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  sirq_host #(.NUM_FRAMES(16), .IDLE_GAP(GAP)) i_sirq_host (
    .clk           (clk),
    .rst_n         (rst_n),
    .quiet_mode_i  (quiet_sel),
    .start_width_i (start_width),
    .line_i        (line_in),
    .line_oe_o     (line_oe),
    .line_out_o    (line_out),
    .irq_vec_o     (irq_vec)
  );

  // {glitch, quiet_next, width[2:0], pattern[15:0]}
  localparam logic [20:0] VEC [6] = '{
    {1'b0, 1'b0, 3'd0, 16'hA5C3},
    {1'b1, 1'b1, 3'd4, 16'h0001},
    {1'b0, 1'b1, 3'd2, 16'h8000},
    {1'b0, 1'b0, 3'd7, 16'hFFFF},
    {1'b0, 1'b0, 3'd6, 16'h0000},
    {1'b0, 1'b0, 3'd1, 16'h5A5A}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a negedge in the first idle clock; returns at the first idle clock after the stop frame.
  task automatic run_cycle(input logic [20:0] v, input bit prev_quiet, input int gap, input logic [15:0] old_vec);
    logic        g, q;
    logic [2:0]  w;
    logic [15:0] pat;
    int n, full;
    g = v[20]; q = v[19]; w = v[18:16]; pat = v[15:0];
    full = (w > 3'd4) ? 8 : 4 + int'(w);
    start_width = w;
    quiet_sel   = q;
    if (prev_quiet) begin
      for (int i = 0; i < 6; i++) begin
        chk(!line_oe, "R3 no host start in quiet idle", 32'(line_oe), 0);
        @(negedge clk);
      end
      line_in = 1'b0;
      @(negedge clk);
      line_in = 1'b1;
      n = 0;
      while (line_oe && !line_out && n < 20) begin n++; @(negedge clk); end
      chk(n == full - 1, "R3 quiet host low length", 32'(n), 32'(full - 1));
    end else begin
      n = 0;
      while (!line_oe && n < 40) begin
        line_in = (g && n == 0) ? 1'b0 : 1'b1;
        n++;
        @(negedge clk);
      end
      line_in = 1'b1;
      chk(n == gap, "R8/R1 idle clocks before start", 32'(n), 32'(gap));
      n = 0;
      while (line_oe && !line_out && n < 20) begin n++; @(negedge clk); end
      chk(n == full, "R2 continuous start low length", 32'(n), 32'(full));
    end
    chk(line_oe && line_out, "R4 high clock after start", {30'd0, line_oe, line_out}, 32'h3);
    @(negedge clk);
    for (int k = 0; k < 48; k++) begin
      chk(!line_oe, "R4 released during frames", 32'(line_oe), 0);
      if (k == 0 || k == 47) chk(irq_vec == old_vec, "R7 vector held in cycle", 32'(irq_vec), 32'(old_vec));
      line_in = (k % 3 == 0) ? ~pat[k / 3] : 1'b1;
      @(negedge clk);
    end
    line_in = 1'b1;
    n = 0;
    while (line_oe && !line_out && n < 20) begin n++; @(negedge clk); end
    chk(n == (q ? 2 : 3), "R6/R9 stop low length", 32'(n), q ? 32'd2 : 32'd3);
    chk(line_oe && line_out, "R6 high clock after stop", {30'd0, line_oe, line_out}, 32'h3);
    chk(irq_vec == old_vec, "R7 vector held until stop ends", 32'(irq_vec), 32'(old_vec));
    @(negedge clk);
    chk(!line_oe, "R6 release after stop", 32'(line_oe), 0);
    chk(irq_vec == pat, "R5 rebuilt request vector", 32'(irq_vec), 32'(pat));
  endtask

  initial begin
    rst_n       = 1'b0;
    quiet_sel   = 1'b0;
    start_width = 3'd0;
    line_in     = 1'b1;
    #3;
    chk(!line_oe, "R1 reset pad enable", 32'(line_oe), 0);
    chk(irq_vec == 16'h0, "R1 reset vector", 32'(irq_vec), 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    // table walk: mode of each cycle comes from the previous stop frame (R9)
    for (int i = 0; i < 6; i++) begin
      run_cycle(VEC[i], (i == 0) ? 1'b0 : VEC[i-1][19], (i == 0) ? 1 : GAP,
                (i == 0) ? 16'h0 : VEC[i-1][15:0]);
    end
    // directed: enter quiet mode, then reset mid-idle
    run_cycle({1'b0, 1'b1, 3'd3, 16'h1234}, 1'b0, GAP, VEC[5][15:0]);
    @(negedge clk);
    chk(!line_oe, "R3 quiet idle stays released", 32'(line_oe), 0);
    rst_n = 1'b0;
    #1;
    chk(!line_oe, "R1 reset releases line", 32'(line_oe), 0);
    chk(irq_vec == 16'h0, "R1 reset clears vector", 32'(irq_vec), 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    // after reset, continuous mode: host starts at once
    run_cycle({1'b0, 1'b0, 3'd0, 16'h00F0}, 1'b0, 1, 16'h0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule